// File: doc/BRIEF.md
# Calendar Clock Counter with Alarm

This block is a synchronous time-of-day and calendar counter. It keeps seconds, minutes, hours, day of week, date of month, month and a two-digit year. A single-cycle `tick` pulse, supplied once per second by logic outside the block, advances the count. Each rollover carries into the next field, up to the year. Month lengths follow the calendar, and February gains a 29th day whenever the year is a multiple of four.

Software reaches ten byte locations through a flat register port. Each read or write can use either plain binary or packed BCD, selected by `bcd_mode`. Hours can be shown in 24-hour form, or in 12-hour form with bit 7 of the hour byte marking PM, selected by `hr12_mode`. Values are held internally in one canonical binary form, so changing either mode changes only how the bytes are shown and parsed.

Seconds, minutes and hours each have an alarm register. When a tick brings all three time fields equal to their alarm values, `alarm_hit` pulses for exactly one cycle.

Top module: `cal_clock`

## Requirements
- R1: Locations are 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month and 9 year. `rdata` shows the addressed location combinationally. Addresses 10 to 15 read as 0x00, and writes to them change no location.
- R2: After reset the time is 00:00:00, day of week 1 (Sunday), date 1, month 1 and year 0. All alarm registers are midnight.
- R3: Fields change only when `tick` or a write occurs. On a tick, seconds increment; 59 wraps to 0 and increments minutes, and minutes wrap from 59 to 0 in the same way.
- R4: Hours run from 0 to 23. A tick at 23:59:59 gives 00:00:00, advances the date, and advances day of week, which wraps from 7 to 1.
- R5: The date wraps to 1 after the last day of the month and advances the month. April, June, September and November have 30 days, the other months have 31, and February has 29 when the year is divisible by 4 and 28 otherwise.
- R6: The month wraps from 12 to 1 and advances the year. The year wraps from 99 to 0.
- R7: With `bcd_mode`=1, bytes are read and written as packed BCD (tens in bits 7:4, units in bits 3:0). With `bcd_mode`=0 they are plain binary, so a year of 99 reads 0x63 in binary mode and 0x99 in BCD mode.
- R8: With `hr12_mode`=1, both hour locations hold 1 to 12 in bits 6:0, with bit 7 set for PM. Midnight is 12 AM and noon is 12 PM. The sequence 11 AM, 12 PM, 1 PM applies, and 11 PM is followed by 12 AM.
- R9: `alarm_hit` is high for exactly the one cycle that follows a tick which leaves seconds, minutes and hours equal to their alarm registers. It is low otherwise.
- R10: When a write to a time field and a tick occur in the same cycle, the written value is stored. That value then advances on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| bcd_mode | input | 1 | 1 = packed BCD bytes, 0 = binary bytes |
| hr12_mode | input | 1 | 1 = 12-hour hour bytes with PM in bit 7, 0 = 24-hour |
| addr | input | 4 | Register location |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte of the addressed location |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The bench targets each carry boundary: 59 to 0 on seconds and minutes, 23:59:59 to midnight with the day-of-week wrap, the 30-day and 31-day month ends, February in leap and common years, and December 31 of year 99. An off-by-one counter would show a 60 or a 32 here, or it would skip a day. In 12-hour mode the bench checks the AM/PM flip at 11:59:59 and the 12-to-1 step; a design that flips on the 12-to-1 step would report 12 PM as AM. It reads the same stored year in both encodings, and checks that the alarm pulse is one cycle wide and absent on a near-miss. It also checks that a write in the same cycle as a tick keeps the written value; a design that gave the tick priority would lose that write.

// File: rtl/cal_clock.sv
module cal_clock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bcd_mode,
  input  logic       hr12_mode,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_hit
);

  logic [6:0] sec, min, hr, dow, date, mon, yr;
  logic [6:0] asec, amin, ahr;
  logic [6:0] n_sec, n_min, n_hr, n_dow, n_date, n_mon, n_yr;
  logic [6:0] mlen;
  logic [6:0] din, hin;

  function automatic [6:0] dec(input logic [7:0] b, input logic bcd);
    dec = bcd ? (7'(b[7:4]) * 7'd10 + 7'(b[3:0])) : b[6:0];
  endfunction

  function automatic [7:0] enc(input logic [6:0] v, input logic bcd);
    enc = bcd ? {4'(v / 7'd10), 4'(v % 7'd10)} : {1'b0, v};
  endfunction

  function automatic [6:0] hour_in(input logic [7:0] b, input logic bcd, input logic h12);
    logic [6:0] v;
    v = dec({1'b0, b[6:0]}, bcd);
    if (!h12)            hour_in = dec(b, bcd);
    else if (v == 7'd12) hour_in = b[7] ? 7'd12 : 7'd0;
    else                 hour_in = b[7] ? v + 7'd12 : v;
  endfunction

  function automatic [7:0] hour_out(input logic [6:0] h, input logic bcd, input logic h12);
    logic [6:0] v;
    logic [7:0] e;
    v = (h == 7'd0) ? 7'd12 : ((h > 7'd12) ? h - 7'd12 : h);
    e = enc(v, bcd);
    hour_out = h12 ? {(h >= 7'd12), e[6:0]} : enc(h, bcd);
  endfunction

  assign din = dec(wdata, bcd_mode);
  assign hin = hour_in(wdata, bcd_mode, hr12_mode);

  always_comb begin
    case (mon)
      7'd2:                        mlen = (yr[1:0] == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:     mlen = 7'd30;
      default:                     mlen = 7'd31;
    endcase
  end

  always_comb begin
    n_sec = sec; n_min = min; n_hr = hr; n_dow = dow;
    n_date = date; n_mon = mon; n_yr = yr;
    if (tick) begin
      n_sec = (sec == 7'd59) ? 7'd0 : sec + 7'd1;
      if (sec == 7'd59) begin
        n_min = (min == 7'd59) ? 7'd0 : min + 7'd1;
        if (min == 7'd59) begin
          n_hr = (hr == 7'd23) ? 7'd0 : hr + 7'd1;
          if (hr == 7'd23) begin
            n_dow  = (dow == 7'd7) ? 7'd1 : dow + 7'd1;
            n_date = (date == mlen) ? 7'd1 : date + 7'd1;
            if (date == mlen) begin
              n_mon = (mon == 7'd12) ? 7'd1 : mon + 7'd1;
              if (mon == 7'd12)
                n_yr = (yr == 7'd99) ? 7'd0 : yr + 7'd1;
            end
          end
        end
      end
    end
    if (wr_en) begin
      case (addr)
        4'd0: n_sec  = din;
        4'd2: n_min  = din;
        4'd4: n_hr   = hin;
        4'd6: n_dow  = din;
        4'd7: n_date = din;
        4'd8: n_mon  = din;
        4'd9: n_yr   = din;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= 7'd0; min <= 7'd0; hr <= 7'd0; dow <= 7'd1;
      date <= 7'd1; mon <= 7'd1; yr <= 7'd0;
      asec <= 7'd0; amin <= 7'd0; ahr <= 7'd0;
      alarm_hit <= 1'b0;
    end else begin
      sec <= n_sec; min <= n_min; hr <= n_hr; dow <= n_dow;
      date <= n_date; mon <= n_mon; yr <= n_yr;
      if (wr_en && addr == 4'd1) asec <= din;
      if (wr_en && addr == 4'd3) amin <= din;
      if (wr_en && addr == 4'd5) ahr  <= hin;
      alarm_hit <= tick && (n_sec == asec) && (n_min == amin) && (n_hr == ahr);
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = enc(sec, bcd_mode);
      4'd1:    rdata = enc(asec, bcd_mode);
      4'd2:    rdata = enc(min, bcd_mode);
      4'd3:    rdata = enc(amin, bcd_mode);
      4'd4:    rdata = hour_out(hr, bcd_mode, hr12_mode);
      4'd5:    rdata = hour_out(ahr, bcd_mode, hr12_mode);
      4'd6:    rdata = enc(dow, bcd_mode);
      4'd7:    rdata = enc(date, bcd_mode);
      4'd8:    rdata = enc(mon, bcd_mode);
      4'd9:    rdata = enc(yr, bcd_mode);
      default: rdata = 8'h00;
    endcase
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sec < 7'd60); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable({sec, min, hr, dow, date, mon, yr})); // R3
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) hr < 7'd24); // R4
  AST_MONTH_END: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && sec == 7'd59 && min == 7'd59 && hr == 7'd23 && date == mlen) |=> (date == 7'd1)); // R5
  AST_YEAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) yr < 7'd100); // R6
  AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> !alarm_hit); // R9

endmodule

// File: tb/sim_cal_clock.sv
`timescale 1ns/1ps
module sim_cal_clock;
  logic clk = 0, rst_n = 0, tick = 0, bcd_mode = 0, hr12_mode = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic alarm_hit;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_clock u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .bcd_mode(bcd_mode),
    .hr12_mode(hr12_mode), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .alarm_hit(alarm_hit));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(string req, logic [3:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic tk();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic eod();
    wr(4, 8'd23); wr(2, 8'd59); wr(0, 8'd59);
  endtask

  task automatic t_reset();
    rd("R2 sec", 0, 8'h00); rd("R2 hour", 4, 8'h00); rd("R2 dow", 6, 8'h01);
    rd("R2 date", 7, 8'h01); rd("R2 month", 8, 8'h01); rd("R2 year", 9, 8'h00);
    rd("R2 alarm hour", 5, 8'h00);
    chk("R2 alarm_hit", {7'd0, alarm_hit}, 8'h00);
  endtask

  task automatic t_addr();
    wr(4'd12, 8'h33);
    rd("R1 unused addr", 4'd12, 8'h00);
    rd("R1 sec untouched", 0, 8'h00);
    wr(1, 8'd17); rd("R1 sec alarm", 1, 8'd17); rd("R1 min alarm", 3, 8'h00);
  endtask

  task automatic t_sec_roll();
    wr(2, 8'd5); wr(0, 8'd58);
    tk(); rd("R3 sec 59", 0, 8'd59);
    repeat (4) @(negedge clk);
    rd("R3 hold without tick", 0, 8'd59);
    tk(); rd("R3 sec wrap", 0, 8'd0); rd("R3 min carry", 2, 8'd6);
    wr(2, 8'd59); wr(0, 8'd59); wr(4, 8'd7);
    tk(); rd("R3 min wrap", 2, 8'd0); rd("R3 hour carry", 4, 8'd8);
  endtask

  task automatic t_day_roll();
    wr(6, 8'd7); wr(8, 8'd3); wr(7, 8'd10); wr(9, 8'd0); eod();
    tk();
    rd("R4 hour wrap", 4, 8'd0); rd("R4 dow wrap", 6, 8'd1); rd("R4 date +1", 7, 8'd11);
  endtask

  task automatic t_month();
    wr(8, 8'd4); wr(7, 8'd30); eod(); tk();
    rd("R5 30-day date", 7, 8'd1); rd("R5 30-day month", 8, 8'd5);
    wr(8, 8'd5); wr(7, 8'd30); eod(); tk();
    rd("R5 31-day keeps", 7, 8'd31);
    wr(9, 8'd24); wr(8, 8'd2); wr(7, 8'd28); eod(); tk();
    rd("R5 leap feb 29", 7, 8'd29);
    eod(); tk(); rd("R5 leap mar 1", 8, 8'd3);
    wr(9, 8'd23); wr(8, 8'd2); wr(7, 8'd28); eod(); tk();
    rd("R5 common feb end", 7, 8'd1); rd("R5 common month", 8, 8'd3);
  endtask

  task automatic t_year();
    wr(9, 8'd5); wr(8, 8'd12); wr(7, 8'd31); eod(); tk();
    rd("R6 year +1", 9, 8'd6); rd("R6 month wrap", 8, 8'd1);
    wr(9, 8'd99); wr(8, 8'd12); wr(7, 8'd31); eod(); tk();
    rd("R6 year wrap", 9, 8'd0); rd("R6 date", 7, 8'd1);
  endtask

  task automatic t_bcd();
    bcd_mode = 1;
    wr(9, 8'h99); rd("R7 bcd year", 9, 8'h99);
    bcd_mode = 0; rd("R7 binary year", 9, 8'h63); bcd_mode = 1;
    wr(4, 8'h23); wr(2, 8'h59); wr(0, 8'h48);
    tk(); rd("R7 bcd sec", 0, 8'h49);
    wr(0, 8'h59); tk();
    rd("R7 bcd sec wrap", 0, 8'h00); rd("R7 bcd hour wrap", 4, 8'h00);
    bcd_mode = 0;
  endtask

  task automatic t_12h();
    hr12_mode = 1;
    wr(4, 8'h8B); wr(2, 8'd59); wr(0, 8'd59); tk();
    rd("R8 11PM to 12AM", 4, 8'h0C);
    wr(4, 8'h0B); wr(2, 8'd59); wr(0, 8'd59); tk();
    rd("R8 11AM to 12PM", 4, 8'h8C);
    wr(2, 8'd59); wr(0, 8'd59); tk();
    rd("R8 12PM to 1PM", 4, 8'h81);
    bcd_mode = 1;
    wr(4, 8'h91); wr(2, 8'h59); wr(0, 8'h59); tk();
    rd("R8 bcd 12AM", 4, 8'h12);
    hr12_mode = 0; bcd_mode = 0;
    rd("R8 12AM is hour 0", 4, 8'h00);
  endtask

  task automatic t_alarm();
    wr(1, 8'd10); wr(3, 8'd2); wr(5, 8'd3);
    wr(4, 8'd3); wr(2, 8'd2); wr(0, 8'd9);
    tk(); #1; chk("R9 hit on match", {7'd0, alarm_hit}, 8'h01);
    @(negedge clk); #1; chk("R9 one cycle", {7'd0, alarm_hit}, 8'h00);
    tk(); #1; chk("R9 no hit after", {7'd0, alarm_hit}, 8'h00);
    wr(4, 8'd4); wr(0, 8'd9);
    tk(); #1; chk("R9 hour mismatch", {7'd0, alarm_hit}, 8'h00);
  endtask

  task automatic t_wr_tick();
    wr(0, 8'd20);
    @(negedge clk); addr = 0; wdata = 8'd40; wr_en = 1; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
    rd("R10 write wins", 0, 8'd40);
    tk(); rd("R10 next tick", 0, 8'd41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_addr(); t_sec_roll(); t_day_roll(); t_month();
    t_year(); t_bcd(); t_12h(); t_alarm(); t_wr_tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule